// File: doc/BRIEF.md
# Privilege-Banked Register File

This block holds the architectural registers of a 16-bit processor. An instruction names a register with a 3-bit index. The lower four indices always reach the same four shared general registers. The upper four indices are banked by privilege. In kernel mode they reach the system registers: the instruction pointer, the stack pointer, the return-address register and the status register. In user mode they reach four extra general registers, and the system registers are out of sight.

Each access carries a system-bank override bit. The bit forces the upper indices onto the system registers whatever the mode is, so stack pushes and pops can always reach the stack pointer. The privilege mode is not an input. It is bit 12 of the status register held here, so software enters or leaves kernel mode by writing that register.

The block has two combinational read ports and one write port. The write port commits on the rising clock edge. Besides full-width writes, the write port can load an 8-bit immediate into the low byte or into the high byte of a register.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 3 select the four shared registers in both modes, with or without the override bit.
- R2: With the mode bit set (kernel), indices 4, 5, 6 and 7 select the instruction pointer, the stack pointer, the return-address register and the status register, in that order.
- R3: With the mode bit clear (user) and no override, indices 4 to 7 select four user-only registers, and the system registers are neither read nor written. The user-only registers keep their contents across mode changes.
- R4: The override bit belongs to a single access, whether a read on either port or a write. When it is set, indices 4 to 7 select the system registers in either mode.
- R5: The instruction pointer stores 24 bits. Every other register stores 16 bits: a read returns it zero-extended to 24 bits, and a write drops `wr_data[23:16]`.
- R6: `wr_kind` = 2'b00 is a full-width write. `wr_kind` = 2'b01 (low byte) puts `wr_data[7:0]` into bits 7:0 and clears every bit above bit 7.
- R7: `wr_kind` = 2'b10 (high byte) puts `wr_data[7:0]` into bits 15:8 and leaves all other bits unchanged.
- R8: `kernel_mode` equals bit 12 of the status register (1 means kernel). A write that changes the bit takes effect in the cycle after the write edge, both at this output and in the bank selection.
- R9: Reads are combinational. A read of a register that is being written in the same cycle returns the value from before the edge.
- R10: A synchronous active-high reset clears every register to zero, which leaves the block in user mode.
- R11: With `wr_en` low, or with `wr_kind` = 2'b11, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_sys | input | 1 | Read port A system-bank override |
| rd_a_data | output | 24 | Read port A data, zero-extended for 16-bit registers |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_sys | input | 1 | Read port B system-bank override |
| rd_b_data | output | 24 | Read port B data, zero-extended for 16-bit registers |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_sys | input | 1 | Write system-bank override |
| wr_kind | input | 2 | 00 full, 01 low byte, 10 high byte, 11 no write |
| wr_data | input | 24 | Write data; byte writes use bits 7:0 |
| kernel_mode | output | 1 | Current privilege mode, 1 = kernel |

## Verification
The hardest case to reach is kernel mode. After reset the block is in user mode, and the status register is hidden. The only way in is an override write of bit 12 through index 7. The stimulus does exactly that. It first fills the user-only registers and, through the override, the stack pointer. It then enters kernel mode, uses the instruction pointer's full 24 bits together with both byte-write kinds, and leaves kernel mode with a low-byte write to the status register. Finally it reads the user-only registers back to confirm that banking preserved them.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
  typedef enum logic [1:0] {
    WK_FULL = 2'b00,
    WK_LOW  = 2'b01,
    WK_HIGH = 2'b10,
    WK_NONE = 2'b11
  } wr_kind_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bank_map.sv
module bank_map #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned PHYS_W = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              kernel,
  input  logic              sys_ovr,
  output logic [PHYS_W-1:0] phys
);
  localparam int unsigned HALF = 2 ** (IDX_W - 1);

  // Physical layout: 0..HALF-1 shared, HALF..2*HALF-1 user-only,
  // 2*HALF..3*HALF-1 system bank.
  always_comb begin
    phys = PHYS_W'(idx);
    if (idx[IDX_W-1] && (kernel || sys_ovr))
      phys = PHYS_W'(idx) + PHYS_W'(HALF);
  end
endmodule

// File: rtl/phys_store.sv
module phys_store
  import bregs_pkg::*;
#(
  parameter int unsigned NPHYS       = 12,
  parameter int unsigned PHYS_W      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned IP_W        = 24,
  parameter int unsigned IP_SLOT     = 8,
  parameter int unsigned STATUS_SLOT = 11,
  parameter int unsigned MODE_BIT    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PHYS_W-1:0] wslot,
  input  logic [1:0]        kind,
  input  logic [IP_W-1:0]   wdata,
  input  logic [PHYS_W-1:0] rslot_a,
  input  logic [PHYS_W-1:0] rslot_b,
  output logic [IP_W-1:0]   rdata_a,
  output logic [IP_W-1:0]   rdata_b,
  output logic              kernel
);
  logic [IP_W-1:0] slot_val [NPHYS];

  for (genvar i = 0; i < NPHYS; i++) begin : g_slot
    localparam int unsigned W = (i == IP_SLOT) ? IP_W : DATA_W;
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we && (wslot == PHYS_W'(i))) begin
        case (kind)
          WK_FULL: q <= wdata[W-1:0];
          WK_LOW:  q <= W'(wdata[BYTE_W-1:0]);
          WK_HIGH: q[2*BYTE_W-1:BYTE_W] <= wdata[BYTE_W-1:0];
          default: q <= q;
        endcase
      end
    end

    assign slot_val[i] = IP_W'(q);
  end

  assign rdata_a = slot_val[rslot_a];
  assign rdata_b = slot_val[rslot_b];
  assign kernel  = slot_val[STATUS_SLOT][MODE_BIT];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IP_W     = 24,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned MODE_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic              rd_a_sys,
  output logic [IP_W-1:0]   rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              rd_b_sys,
  output logic [IP_W-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_sys,
  input  logic [1:0]        wr_kind,
  input  logic [IP_W-1:0]   wr_data,
  output logic              kernel_mode
);
  localparam int unsigned HALF        = 2 ** (IDX_W - 1);
  localparam int unsigned NPHYS       = 3 * HALF;
  localparam int unsigned PHYS_W      = $clog2(NPHYS);
  localparam int unsigned IP_SLOT     = 2 * HALF;
  localparam int unsigned STATUS_SLOT = 3 * HALF - 1;
  localparam int unsigned NACC        = 3;

  logic [IDX_W-1:0]  acc_idx  [NACC];
  logic              acc_sys  [NACC];
  logic [PHYS_W-1:0] acc_phys [NACC];
  logic              kern;

  // access 0: read A, 1: read B, 2: write
  assign acc_idx[0] = rd_a_idx;
  assign acc_sys[0] = rd_a_sys;
  assign acc_idx[1] = rd_b_idx;
  assign acc_sys[1] = rd_b_sys;
  assign acc_idx[2] = wr_idx;
  assign acc_sys[2] = wr_sys;

  for (genvar p = 0; p < NACC; p++) begin : g_map
    bank_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map (
      .idx     (acc_idx[p]),
      .kernel  (kern),
      .sys_ovr (acc_sys[p]),
      .phys    (acc_phys[p])
    );
  end

  phys_store #(
    .NPHYS(NPHYS), .PHYS_W(PHYS_W), .DATA_W(DATA_W), .IP_W(IP_W),
    .IP_SLOT(IP_SLOT), .STATUS_SLOT(STATUS_SLOT), .MODE_BIT(MODE_BIT)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .wslot   (acc_phys[2]),
    .kind    (wr_kind),
    .wdata   (wr_data),
    .rslot_a (acc_phys[0]),
    .rslot_b (acc_phys[1]),
    .rdata_a (rd_a_data),
    .rdata_b (rd_b_data),
    .kernel  (kern)
  );

  assign kernel_mode = kern;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import bregs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IP_W   = 24,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic              rd_a_sys,
  input logic [IP_W-1:0]   rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic              rd_b_sys,
  input logic [IP_W-1:0]   rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [1:0]        wr_kind,
  input logic [DATA_W-1:0] wr_data,
  input logic              kernel_mode
);
  localparam int unsigned HALF = 2 ** (IDX_W - 1);

  p_shared_full_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == WK_FULL && !wr_idx[IDX_W-1]) |=>
      (rd_a_idx != $past(wr_idx)) || (rd_a_data == IP_W'($past(wr_data))));

  p_low_byte_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == WK_LOW && !wr_idx[IDX_W-1]) |=>
      (rd_a_idx != $past(wr_idx)) || (rd_a_data == IP_W'($past(wr_data[7:0]))));

  p_high_byte_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == WK_HIGH && !wr_idx[IDX_W-1] && rd_b_idx == wr_idx) |=>
      (rd_b_idx != $past(wr_idx)) ||
      (rd_b_data[15:8] == $past(wr_data[7:0]) && rd_b_data[7:0] == $past(rd_b_data[7:0])));

  p_narrow_a_r5: assert property (@(posedge clk) disable iff (rst)
    !(rd_a_idx == IDX_W'(HALF) && (kernel_mode || rd_a_sys)) |->
      rd_a_data[IP_W-1:DATA_W] == '0);

  p_narrow_b_r5: assert property (@(posedge clk) disable iff (rst)
    !(rd_b_idx == IDX_W'(HALF) && (kernel_mode || rd_b_sys)) |->
      rd_b_data[IP_W-1:DATA_W] == '0);

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_kind == WK_NONE) |=> $stable(kernel_mode));

  p_reset_user_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !kernel_mode);
endmodule

bind banked_regfile banked_regfile_chk #(
  .DATA_W(DATA_W), .IP_W(IP_W), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_a_idx    (rd_a_idx),
  .rd_a_sys    (rd_a_sys),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_sys    (rd_b_sys),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_kind     (wr_kind),
  .wr_data     (wr_data[DATA_W-1:0]),
  .kernel_mode (kernel_mode)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        rd_a_sys = 1'b0, rd_b_sys = 1'b0, wr_sys = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_kind = 2'b00;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_a_data, rd_b_data;
  logic        kernel_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          what;   // 0 port A, 1 port B, 2 mode
    logic [23:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_sys(rd_a_sys), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_sys(rd_b_sys), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sys(wr_sys), .wr_kind(wr_kind),
    .wr_data(wr_data), .kernel_mode(kernel_mode)
  );

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [23:0] act;
        it = sb.pop_front();
        act = (it.what == 0) ? rd_a_data : (it.what == 1) ? rd_b_data : {23'b0, kernel_mode};
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] idx, input logic sys, input logic [1:0] kind,
                    input logic [23:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sys = sys; wr_kind = kind; wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic wr_off(input logic [2:0] idx, input logic [1:0] kind, input logic en,
                        input logic [23:0] data);
    @(negedge clk);
    wr_en = en; wr_idx = idx; wr_sys = 1'b0; wr_kind = kind; wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int port, input logic [2:0] idx, input logic sys,
                    input logic [23:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    if (port == 0) begin rd_a_idx = idx; rd_a_sys = sys; end
    else begin rd_b_idx = idx; rd_b_sys = sys; end
    it.what = port; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_mode(input logic m, input string tag);
    item_t it;
    @(negedge clk);
    it.what = 2; it.exp = {23'b0, m}; it.tag = tag;
    sb.push_back(it);
  endtask

  // write and read the same register in one cycle
  task automatic wr_rd(input logic [2:0] idx, input logic [23:0] data,
                       input logic [23:0] old, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sys = 1'b0; wr_kind = 2'b00; wr_data = data;
    rd_a_idx = idx; rd_a_sys = 1'b0;
    it.what = 0; it.exp = old; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < 8; i++) rd(0, 3'(i), 1'b0, 24'h0, "R10 reset clears register");
    for (int i = 4; i < 8; i++) rd(1, 3'(i), 1'b1, 24'h0, "R10 reset clears system register");
    chk_mode(1'b0, "R10 reset leaves user mode");

    wr(3'd0, 1'b0, 2'b00, 24'h001111);
    wr(3'd1, 1'b0, 2'b00, 24'h002222);
    wr(3'd2, 1'b0, 2'b00, 24'h003333);
    wr(3'd3, 1'b0, 2'b00, 24'h004444);
    wr(3'd4, 1'b0, 2'b00, 24'h005555);
    wr(3'd5, 1'b0, 2'b00, 24'h006666);
    wr(3'd6, 1'b0, 2'b00, 24'h007777);
    wr(3'd7, 1'b0, 2'b00, 24'h008888);
    rd(0, 3'd0, 1'b0, 24'h001111, "R1 shared reg 0 user");
    rd(0, 3'd3, 1'b1, 24'h004444, "R1 shared reg 3 with override");
    rd(1, 3'd4, 1'b0, 24'h005555, "R3 user reg at index 4");
    rd(1, 3'd7, 1'b0, 24'h008888, "R3 user reg at index 7");
    rd(0, 3'd4, 1'b1, 24'h000000, "R3 user writes did not reach system bank");
    rd(1, 3'd7, 1'b1, 24'h000000, "R3 status untouched by user write");

    wr(3'd0, 1'b0, 2'b00, 24'hFF9ABC);
    rd(0, 3'd0, 1'b0, 24'h009ABC, "R5 16-bit reg drops upper write bits");
    wr(3'd1, 1'b0, 2'b01, 24'h00FF5A);
    rd(0, 3'd1, 1'b0, 24'h00005A, "R6 low byte clears upper bits");
    wr(3'd2, 1'b0, 2'b10, 24'h0000AB);
    rd(1, 3'd2, 1'b0, 24'h00AB33, "R7 high byte keeps low byte");

    wr_rd(3'd3, 24'h000F0F, 24'h004444, "R9 read during write returns old");
    rd(0, 3'd3, 1'b0, 24'h000F0F, "R9 new value visible next cycle");

    wr_off(3'd0, 2'b00, 1'b0, 24'h00DEAD);
    rd(0, 3'd0, 1'b0, 24'h009ABC, "R11 write enable low ignored");
    wr_off(3'd1, 2'b11, 1'b1, 24'h00DEAD);
    rd(0, 3'd1, 1'b0, 24'h00005A, "R11 kind 11 writes nothing");

    wr(3'd5, 1'b1, 2'b00, 24'h00BEEF);
    rd(0, 3'd5, 1'b0, 24'h006666, "R4 override write spared user reg");
    rd(1, 3'd5, 1'b1, 24'h00BEEF, "R4 override reads stack pointer");

    wr(3'd7, 1'b1, 2'b00, 24'h001000);
    chk_mode(1'b1, "R8 mode bit set enters kernel");
    rd(0, 3'd7, 1'b0, 24'h001000, "R2 index 7 is status in kernel");
    rd(1, 3'd5, 1'b0, 24'h00BEEF, "R2 index 5 is stack pointer in kernel");
    rd(0, 3'd0, 1'b0, 24'h009ABC, "R1 shared reg 0 kernel");
    wr(3'd4, 1'b0, 2'b00, 24'hABCDEF);
    rd(0, 3'd4, 1'b0, 24'hABCDEF, "R5 instruction pointer keeps 24 bits");
    wr(3'd6, 1'b0, 2'b00, 24'h000246);
    rd(1, 3'd6, 1'b0, 24'h000246, "R2 index 6 is return register in kernel");
    wr(3'd4, 1'b0, 2'b01, 24'h000012);
    rd(0, 3'd4, 1'b0, 24'h000012, "R6 low byte on pointer clears bits 23:8");
    wr(3'd4, 1'b0, 2'b10, 24'h000034);
    rd(0, 3'd4, 1'b0, 24'h003412, "R7 high byte on pointer");

    wr(3'd7, 1'b0, 2'b01, 24'h000000);
    chk_mode(1'b0, "R8 clearing mode bit returns to user");
    rd(0, 3'd4, 1'b0, 24'h005555, "R3 user reg preserved across kernel");
    rd(1, 3'd6, 1'b0, 24'h007777, "R3 user reg 6 preserved");
    rd(0, 3'd4, 1'b1, 24'h003412, "R4 override reaches pointer in user mode");

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule